// File: doc/BRIEF.md
# I2C Master Command and Byte Engine

This block drives an I2C bus as a controller under register control. Software issues bus conditions (START, repeated START, STOP) through a control/status register and sends a byte by writing a data register. The engine then clocks the eight data bits out most significant first, releases SDA for a ninth clock and captures the target's acknowledge. While a command runs, a busy flag is visible in the status register. Each finished command sets a sticky session-done bit that can be routed to an interrupt line.

The bus side is open drain. The block only ever pulls SCL or SDA low, through two output-enable pins, and it reads SDA back to sample the acknowledge. SCL timing comes from the system clock: every SCL bit period is four quarter periods of `QDIV` system clocks each. A condition takes one such slot and a data byte takes nine.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset the status register (offset 0x48) reads 0, so busy (bit 7) and session-done (bit 3) are clear. The interrupt output is low, and neither pad is pulled low.
- R2: Writing the control register (offset 0x20) with enable bit 0 set, command field bits [2:1] = 1 and bit 3 = 0 produces a START: SDA falls while SCL is high, and the command ends with both lines held low.
- R3: The same command with bit 3 = 1 produces a repeated START: SDA is released while SCL is low, SCL rises, then SDA falls while SCL is high.
- R4: Command field value 2 produces a STOP: SDA rises while SCL is high, and afterwards neither line is pulled low.
- R5: Writing the data register (offset 0x28) transmits its low byte most significant bit first. SDA changes only while SCL is low, and SDA is released during the ninth clock.
- R6: After a byte completes, control register bit 3 reads 1 if SDA was high on the ninth SCL high phase (NACK) and 0 if it was low (ACK).
- R7: Busy (status bit 7) is set from the cycle after an accepted command. It stays set for exactly 4*QDIV cycles for a condition and 36*QDIV cycles for a byte.
- R8: While busy, writes to the control or data register are ignored: no extra bus activity occurs and the enable bit keeps its value.
- R9: Session-done sets when any command finishes and stays set until a 1 is written to status bit 3. The interrupt output is high exactly when session-done and interrupt-enable bit 3 (offset 0x44) are both 1.
- R10: Command value 0 with enable set, any command with enable clear, and a data write with enable clear all start nothing: busy and session-done stay clear and the bus is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte offset for writes and reads |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr` (combinational) |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the acknowledge sample. It depends on a second party pulling SDA low only during the ninth SCL pulse, and on the engine sampling in that window rather than one quarter early or late. The bench contains a small target model that watches the bus lines, counts SCL rising edges from the last START, and pulls SDA for exactly the ninth clock when told to ACK. A sweep of walking-one and mixed bytes, alternating ACK and NACK, then compares the received byte, the readback bit and the number of START/STOP events, which would rise if SDA ever moved while SCL was high.

// File: rtl/i2ce_pkg.sv
package i2ce_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_RESTART = 2'd1,
    OP_STOP    = 2'd2,
    OP_BYTE    = 2'd3
  } op_e;

  localparam int BYTE_BITS   = 8;
  localparam int STAT_BUSY_B = 7;
  localparam int STAT_DONE_B = 3;
  localparam int CTRL_EN_B   = 0;
  localparam int CTRL_ACK_B  = 3;
  localparam int IEN_DONE_B  = 3;

  localparam logic [7:0] OFS_CTRL = 8'h20;
  localparam logic [7:0] OFS_TXD  = 8'h28;
  localparam logic [7:0] OFS_IEN  = 8'h44;
  localparam logic [7:0] OFS_STAT = 8'h48;

  localparam logic [1:0] CMD_NONE = 2'd0;
  localparam logic [1:0] CMD_COND = 2'd1;
  localparam logic [1:0] CMD_STOP = 2'd2;

  // number of 4-quarter slots an operation occupies
  function automatic logic [3:0] op_slots(op_e op);
    return (op == OP_BYTE) ? 4'(BYTE_BITS + 1) : 4'd1;
  endfunction

  // bit to present on SDA in a slot: data MSB first, then released for ack
  function automatic logic slot_bit(logic [7:0] b, logic [3:0] s);
    if (s < 4'(BYTE_BITS)) return b[3'd7 - s[2:0]];
    return 1'b1;
  endfunction

  // {scl, sda} line levels for a given quarter of a slot
  function automatic logic [1:0] quarter_levels(op_e op, logic b, logic [1:0] q);
    logic [1:0] lv;
    case (op)
      OP_START:   lv = (q == 2'd3) ? 2'b00 : (q == 2'd2) ? 2'b10 : 2'b11;
      OP_RESTART: lv = (q == 2'd0) ? 2'b01 : (q == 2'd1) ? 2'b11 :
                       (q == 2'd2) ? 2'b10 : 2'b00;
      OP_STOP:    lv = (q == 2'd0) ? 2'b00 : (q == 2'd1) ? 2'b10 : 2'b11;
      default:    lv = {(q == 2'd1) || (q == 2'd2), b};
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/i2ce_qtimer.sv
module i2ce_qtimer #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (launch) begin
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/i2ce_seq.sv
module i2ce_seq
  import i2ce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  op_e        launch_op,
  input  logic [7:0] launch_byte,
  input  logic       tick,
  input  logic       sda_in,
  output logic       busy,
  output logic       done_pulse,
  output logic       nack,
  output logic       scl_lvl,
  output logic       sda_lvl
);
  localparam logic [3:0] ACK_SLOT = 4'(BYTE_BITS);

  op_e        op_q;
  logic       busy_q, done_q, nack_q, scl_q, sda_q;
  logic [7:0] sh_q;
  logic [3:0] slot_q;
  logic [1:0] qtr_q;

  logic       last_qtr, last_slot, ack_sample, finish;
  logic [3:0] nxt_slot;
  logic [1:0] nxt_qtr;

  assign last_qtr   = (qtr_q == 2'd3);
  assign last_slot  = (slot_q == op_slots(op_q) - 4'd1);
  assign nxt_qtr    = qtr_q + 2'd1;
  assign nxt_slot   = last_qtr ? slot_q + 4'd1 : slot_q;
  assign ack_sample = busy_q && tick && (op_q == OP_BYTE) &&
                      (slot_q == ACK_SLOT) && (qtr_q == 2'd2);
  assign finish     = busy_q && tick && last_qtr && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      nack_q <= 1'b0;
      op_q   <= OP_START;
      sh_q   <= '0;
      slot_q <= '0;
      qtr_q  <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        op_q   <= launch_op;
        sh_q   <= launch_byte;
        slot_q <= '0;
        qtr_q  <= '0;
        {scl_q, sda_q} <= quarter_levels(launch_op, slot_bit(launch_byte, 4'd0), 2'd0);
      end else if (busy_q && tick) begin
        if (ack_sample) nack_q <= sda_in;
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          qtr_q  <= nxt_qtr;
          slot_q <= nxt_slot;
          {scl_q, sda_q} <= quarter_levels(op_q, slot_bit(sh_q, nxt_slot), nxt_qtr);
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done_pulse = done_q;
  assign nack       = nack_q;
  assign scl_lvl    = scl_q;
  assign sda_lvl    = sda_q;

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && op_q == OP_BYTE && scl_q && $past(scl_q)) |-> (sda_q == $past(sda_q))); // R5
  AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_q == OP_BYTE && slot_q == ACK_SLOT) |-> sda_q); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && op_q == OP_STOP) |-> (scl_q && sda_q)); // R4

endmodule

// File: rtl/i2ce_regs.sv
module i2ce_regs
  import i2ce_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          done_pulse,
  input  logic          nack,
  output logic          launch,
  output op_e           launch_op,
  output logic [7:0]    launch_byte,
  output logic          irq
);
  logic       en_q, ack_q, done_q, byte_pend_q;
  logic [1:0] cmd_q;
  logic [7:0] txd_q, ien_q;
  logic       wr_ctrl, wr_txd, wr_ien, wr_stat;
  logic       unused_hi;

  assign unused_hi = ^wdata[DW-1:8];

  assign wr_ctrl = wr_en && (addr == AW'(OFS_CTRL));
  assign wr_txd  = wr_en && (addr == AW'(OFS_TXD));
  assign wr_ien  = wr_en && (addr == AW'(OFS_IEN));
  assign wr_stat = wr_en && (addr == AW'(OFS_STAT));

  always_comb begin
    launch      = 1'b0;
    launch_op   = OP_START;
    launch_byte = wdata[7:0];
    if (!busy) begin
      if (wr_ctrl && wdata[CTRL_EN_B]) begin
        if (wdata[2:1] == CMD_COND) begin
          launch    = 1'b1;
          launch_op = wdata[CTRL_ACK_B] ? OP_RESTART : OP_START;
        end else if (wdata[2:1] == CMD_STOP) begin
          launch    = 1'b1;
          launch_op = OP_STOP;
        end
      end else if (wr_txd && en_q) begin
        launch    = 1'b1;
        launch_op = OP_BYTE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      ack_q       <= 1'b0;
      cmd_q       <= CMD_NONE;
      txd_q       <= '0;
      ien_q       <= '0;
      done_q      <= 1'b0;
      byte_pend_q <= 1'b0;
    end else begin
      if (wr_ctrl && !busy) begin
        en_q  <= wdata[CTRL_EN_B];
        cmd_q <= wdata[2:1];
        ack_q <= wdata[CTRL_ACK_B];
      end
      if (wr_txd && !busy && en_q) txd_q <= wdata[7:0];
      if (done_pulse) begin
        if (byte_pend_q) ack_q <= nack;
        byte_pend_q <= 1'b0;
      end
      if (launch) byte_pend_q <= (launch_op == OP_BYTE);
      if (wr_ien) ien_q <= wdata[7:0];
      if (done_pulse)                        done_q <= 1'b1;
      else if (wr_stat && wdata[STAT_DONE_B]) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(OFS_CTRL))      rdata = DW'({4'b0, ack_q, cmd_q, en_q});
    else if (addr == AW'(OFS_TXD))  rdata = DW'(txd_q);
    else if (addr == AW'(OFS_IEN))  rdata = DW'(ien_q);
    else if (addr == AW'(OFS_STAT)) rdata = DW'({busy, 3'b0, done_q, 3'b0});
  end

  assign irq = done_q && ien_q[IEN_DONE_B];

  AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy); // R7
  AST_NO_LAUNCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !launch); // R8
  AST_EN_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && busy) |=> $stable(en_q)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> done_q); // R9

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2ce_pkg::*;
#(
  parameter int QDIV = 4,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          irq
);
  logic       launch, tick, busy, done_pulse, nack, scl_lvl, sda_lvl;
  op_e        launch_op;
  logic [7:0] launch_byte;

  i2ce_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .busy(busy), .done_pulse(done_pulse), .nack(nack),
    .launch(launch), .launch_op(launch_op), .launch_byte(launch_byte), .irq(irq)
  );

  i2ce_qtimer #(.QDIV(QDIV)) u_qtimer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(busy), .tick(tick)
  );

  i2ce_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
    .launch_byte(launch_byte), .tick(tick), .sda_in(sda_i), .busy(busy),
    .done_pulse(done_pulse), .nack(nack), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
  );

  assign scl_oe = !scl_lvl;
  assign sda_oe = !sda_lvl;

endmodule

// File: tb/tb_i2c_cmd_engine.sv
`timescale 1ns/1ps
module tb_i2c_cmd_engine;
  localparam int QDIV = 4;
  localparam logic [7:0] A_CTRL = 8'h20, A_TXD = 8'h28, A_IEN = 8'h44, A_STAT = 8'h48;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = A_STAT;
  logic [31:0] wdata = '0, rdata;
  logic scl_oe, sda_oe, irq, sda_i;

  int errs = 0, checks = 0;
  bit finished = 0;

  // target model and bus monitor
  logic pull = 1'b0, ack_mode = 1'b0, pscl = 1'b1, psda = 1'b1;
  int starts = 0, stops = 0, bitcnt = 0, rx_count = 0;
  logic [7:0] shreg = '0, rx_byte = '0;

  always #2.5 clk = ~clk;

  assign sda_i = !(sda_oe || pull);

  i2c_cmd_engine #(.QDIV(QDIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  always @(negedge clk) begin
    logic scl_l, sda_l;
    scl_l = !scl_oe;
    sda_l = !(sda_oe || pull);
    if (rst_n) begin
      if (scl_l && pscl && psda && !sda_l) begin starts++; bitcnt = 0; end
      if (scl_l && pscl && !psda && sda_l) stops++;
      if (scl_l && !pscl) begin
        if (bitcnt < 8) shreg = {shreg[6:0], sda_l};
        bitcnt++;
        if (bitcnt == 9) begin rx_byte = shreg; rx_count++; bitcnt = 0; end
      end
      if (!scl_l && pscl) pull = (bitcnt == 8) ? ack_mode : 1'b0;
    end
    pscl = scl_l;
    psda = sda_l;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = A_STAT;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = A_STAT;
  endtask

  // counts cycles with busy set, starting right after a write
  task automatic busy_len(output int n);
    logic [31:0] d;
    n = 0;
    rd(A_STAT, d);
    while (d[7] && n < 10000) begin
      n++;
      @(negedge clk);
      rd(A_STAT, d);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, s0, p0, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, d);
    chk(d == 0, "R1 status", int'(d), 0);
    chk(irq == 0 && scl_oe == 0 && sda_oe == 0, "R1 pads/irq", {irq, scl_oe, sda_oe}, 0);

    // R10 enable clear: nothing starts
    wr(A_CTRL, 32'h02);
    busy_len(n);
    chk(n == 0 && starts == 0, "R10 disabled cmd", n, 0);
    wr(A_TXD, 32'h5A);
    busy_len(n);
    chk(n == 0 && rx_count == 0, "R10 disabled data", n, 0);
    wr(A_CTRL, 32'h01);
    busy_len(n);
    rd(A_STAT, d);
    chk(n == 0 && d == 0 && starts == 0 && stops == 0, "R10 no-action", int'(d), 0);

    // R2 START, R7 length, R9 done/irq
    wr(A_IEN, 32'h08);
    wr(A_CTRL, 32'h03);
    busy_len(n);
    chk(n == 4 * QDIV, "R7 condition busy length", n, 4 * QDIV);
    @(negedge clk);
    chk(starts == 1, "R2 start seen", starts, 1);
    chk(scl_oe == 1 && sda_oe == 1, "R2 lines low after start", {scl_oe, sda_oe}, 3);
    rd(A_STAT, d);
    chk(d[3] == 1 && irq == 1, "R9 done and irq", {d[3], irq}, 3);
    wr(A_IEN, 32'h00);
    chk(irq == 0, "R9 irq masked", irq, 0);
    wr(A_IEN, 32'h08);
    wr(A_STAT, 32'h08);
    rd(A_STAT, d);
    chk(d[3] == 0 && irq == 0, "R9 w1c clears", {d[3], irq}, 0);

    // R5/R6 byte sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = (i < 8) ? (8'h01 << i) : 8'(i * 37 + 3);
      ack_mode = i[0];
      s0 = starts; p0 = stops; r0 = rx_count;
      wr(A_TXD, {24'h0, b});
      busy_len(n);
      chk(n == 36 * QDIV, "R7 byte busy length", n, 36 * QDIV);
      @(negedge clk);
      chk(rx_count == r0 + 1 && rx_byte == b, "R5 byte received", rx_byte, b);
      chk(starts == s0 && stops == p0, "R5 no SDA change with SCL high", starts + stops, s0 + p0);
      rd(A_CTRL, d);
      chk(d[3] == !ack_mode, "R6 ack readback", d[3], !ack_mode);
      wr(A_STAT, 32'h08);
    end
    ack_mode = 1'b0;

    // R8 writes ignored while busy
    s0 = starts; p0 = stops; r0 = rx_count;
    wr(A_TXD, 32'hC3);
    wr(A_TXD, 32'h00);
    wr(A_CTRL, 32'h04);
    wr(A_CTRL, 32'h00);
    busy_len(n);
    repeat (2 * QDIV * 4) @(negedge clk);
    chk(rx_count == r0 + 1 && rx_byte == 8'hC3, "R8 extra data ignored", rx_byte, 8'hC3);
    chk(stops == p0 && starts == s0, "R8 stop ignored", stops, p0);
    rd(A_CTRL, d);
    chk(d[0] == 1, "R8 enable kept", d[0], 1);
    wr(A_STAT, 32'h08);

    // R3 repeated START
    s0 = starts;
    wr(A_CTRL, 32'h0B);
    busy_len(n);
    @(negedge clk);
    chk(starts == s0 + 1 && n == 4 * QDIV, "R3 repeated start", starts, s0 + 1);
    rd(A_STAT, d);
    chk(d[3] == 1, "R9 done after restart", d[3], 1);
    wr(A_STAT, 32'h08);

    // R4 STOP
    p0 = stops;
    wr(A_CTRL, 32'h05);
    busy_len(n);
    @(negedge clk);
    chk(stops == p0 + 1, "R4 stop seen", stops, p0 + 1);
    chk(scl_oe == 0 && sda_oe == 0, "R4 lines released", {scl_oe, sda_oe}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule